// File: doc/BRIEF.md
# Polled SPI Master with Register Interface

This block is a byte-wide SPI master reached through a small register file on a plain 32-bit register bus (address, write strobe, read strobe, write data, combinational read data). Software sets the clock divider and the clock mode in a control word and chooses the chip-select level in a system word. A byte written to the transmit word starts one full-duplex exchange. Software then polls the status word until the engine is idle and reads the received byte back.

The serial clock comes from the system clock through two stages. A prescaler divides by 16 or by 128. A programmable stage then divides by 2×(n+1). Chip select is a plain register bit and the engine never drives it. Word addresses are 0x00 control, 0x04 status, 0x08 system, 0x0C transmit, 0x10 receive and 0x14 auxiliary control. Only aligned accesses take effect.

Top module: `spi_reg_master`

## Requirements
- R1: After reset: sck_o is 0, cs_o is 1, mosi_o is 0. Control, status and receive read 0. System reads 0x40.
- R2: Control (0x00) reads back bits [7:0] as written. System (0x08) keeps only bits 6, 5 and 0. Bits 31:8 of every word, all bits of 0x14 and all bits of unmapped words read 0.
- R3: An aligned write to 0x0C while idle starts one exchange. Status bit 0 reads 1 from the next cycle until the 16th SCK edge, and then reads 0.
- R4: SCK half-period is P×(n+1) system clocks, where n = control[4:0], P = 128 when control bit 5 is 1 and P = 16 when it is 0. The first edge comes one half-period after the start.
- R5: SCK sits at the level of control bit 6 (CPOL) while idle and returns to that level after each byte.
- R6: Data moves MSB first. With control bit 7 (CPHA) at 0, MOSI is valid before the first edge, MISO is sampled on odd edges and MOSI changes on even edges. With CPHA at 1, MOSI changes on odd edges and MISO is sampled on even edges.
- R7: One cycle after status bit 0 clears, status bit 2 is 1 and the receive word (0x10) holds the 8 sampled bits.
- R8: Reading 0x10 clears status bit 2. Writing status with bit 2 at 0 clears it. Writing status with bit 2 at 1 leaves it unchanged.
- R9: A write to 0x0C while status bit 0 is 1 is ignored. The byte being shifted and its timing do not change.
- R10: cs_o always equals system bit 6, which resets to 1.
- R11: mosi_o is 0 whenever no exchange is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address of the register |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; a read of 0x10 has a side effect |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while re_i is high |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select, driven from the system register |

## Verification
The embedded assertions check these points on every cycle:
- SCK edges are never on adjacent cycles.
- The engine never receives a start while busy.
- SCK comes back to idle phase whenever busy falls.
- The receive-full flag follows every completed byte.
- Chip select moves only on a system-register write.

Only the bench's scenarios can show the exact half-period for each prescaler and divider choice, the bit order for all four clock modes, the byte actually captured from MISO, and the clearing rules of the receive flag. For these, a behavioural model of the edge timing is compared against sck_o, mosi_o and cs_o on every clock.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;
  localparam int N_W    = 5;

  // word index = addr[4:2]
  localparam logic [2:0] W_CTRL  = 3'd0;
  localparam logic [2:0] W_STAT  = 3'd1;
  localparam logic [2:0] W_SYS   = 3'd2;
  localparam logic [2:0] W_TX    = 3'd3;
  localparam logic [2:0] W_RX    = 3'd4;

  localparam int C_CPHA = 7;
  localparam int C_CPOL = 6;
  localparam int C_PRE  = 5;
  localparam int S_CS   = 6;
  localparam int S_B5   = 5;
  localparam int S_B0   = 0;
  localparam int ST_BSY = 0;
  localparam int ST_RXF = 2;
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128,
  parameter int N_W    = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           pre_sel_i,
  input  logic [N_W-1:0] n_i,
  output logic           edge_o
);
  localparam int PC_W = $clog2(PRE_HI);

  logic [PC_W-1:0] pre_q, pre_last;
  logic [N_W-1:0]  half_q;
  logic            tick;

  assign pre_last = pre_sel_i ? PC_W'(PRE_HI - 1) : PC_W'(PRE_LO - 1);
  assign tick     = (pre_q == pre_last);
  assign edge_o   = en_i && tick && (half_q == n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      half_q <= '0;
    end else if (!en_i) begin
      pre_q  <= '0;
      half_q <= '0;
    end else if (tick) begin
      pre_q  <= '0;
      half_q <= (half_q == n_i) ? '0 : half_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_EDGE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o); // R4
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] tx_i,
  input  logic         cpha_i,
  input  logic         edge_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         phase_o,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);
  localparam int EC_W = $clog2(2 * W);
  localparam logic [EC_W-1:0] LAST = EC_W'(2 * W - 1);

  logic            busy_q, done_q, phase_q, mosi_q;
  logic [EC_W-1:0] ecnt_q;
  logic [W-1:0]    tx_sh, rx_sh;
  logic            sample;

  // leading edge while phase is 0; CPHA picks which edge samples
  assign sample = (!phase_q) != cpha_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= 1'b0;
      mosi_q  <= 1'b0;
      ecnt_q  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else begin
      done_q <= busy_q && edge_i && (ecnt_q == LAST);
      if (start_i) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        ecnt_q  <= '0;
        if (cpha_i) begin
          mosi_q <= 1'b0;
          tx_sh  <= tx_i;
        end else begin
          mosi_q <= tx_i[W-1];
          tx_sh  <= {tx_i[W-2:0], 1'b0};
        end
      end else if (busy_q && edge_i) begin
        phase_q <= ~phase_q;
        ecnt_q  <= ecnt_q + 1'b1;
        if (sample) begin
          rx_sh <= {rx_sh[W-2:0], miso_i};
        end else begin
          mosi_q <= tx_sh[W-1];
          tx_sh  <= {tx_sh[W-2:0], 1'b0};
        end
        if (ecnt_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign phase_o = phase_q;
  assign mosi_o  = busy_q & mosi_q;
  assign rx_o    = rx_sh;

  AST_IDLE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> !phase_q); // R5
  AST_DONE_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(busy_q) && !busy_q)); // R3
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R9
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_o
);
  logic [BYTE_W-1:0] ctrl_q, rx_buf_q, rx_sh;
  logic              cs_q, sb5_q, sb0_q, rx_full_q;
  logic              busy, done, phase, sck_edge;
  logic              wr, rd, start;
  logic [2:0]        word;

  wire unused_hi = ^wdata_i[DATA_W-1:BYTE_W];

  assign word  = addr_i[4:2];
  assign wr    = we_i && (addr_i[1:0] == 2'b00);
  assign rd    = re_i && (addr_i[1:0] == 2'b00);
  assign start = wr && (word == W_TX) && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      cs_q      <= 1'b1;
      sb5_q     <= 1'b0;
      sb0_q     <= 1'b0;
      rx_full_q <= 1'b0;
      rx_buf_q  <= '0;
    end else begin
      if (wr && word == W_CTRL) ctrl_q <= wdata_i[BYTE_W-1:0];
      if (wr && word == W_SYS) begin
        cs_q  <= wdata_i[S_CS];
        sb5_q <= wdata_i[S_B5];
        sb0_q <= wdata_i[S_B0];
      end
      if (done) begin
        rx_full_q <= 1'b1;
        rx_buf_q  <= rx_sh;
      end else if ((rd && word == W_RX) ||
                   (wr && word == W_STAT && !wdata_i[ST_RXF])) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (word)
        W_CTRL: rdata_o[BYTE_W-1:0] = ctrl_q;
        W_STAT: begin
          rdata_o[ST_BSY] = busy;
          rdata_o[ST_RXF] = rx_full_q;
        end
        W_SYS: begin
          rdata_o[S_CS] = cs_q;
          rdata_o[S_B5] = sb5_q;
          rdata_o[S_B0] = sb0_q;
        end
        W_RX:    rdata_o[BYTE_W-1:0] = rx_buf_q;
        default: rdata_o = '0;
      endcase
    end
  end

  spi_sck_div #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .N_W(N_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (busy),
    .pre_sel_i(ctrl_q[C_PRE]),
    .n_i      (ctrl_q[N_W-1:0]),
    .edge_o   (sck_edge)
  );

  spi_shift_eng #(.W(BYTE_W)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .tx_i   (wdata_i[BYTE_W-1:0]),
    .cpha_i (ctrl_q[C_CPHA]),
    .edge_i (sck_edge),
    .miso_i (miso_i),
    .busy_o (busy),
    .done_o (done),
    .phase_o(phase),
    .mosi_o (mosi_o),
    .rx_o   (rx_sh)
  );

  assign sck_o = ctrl_q[C_CPOL] ^ phase;
  assign cs_o  = cs_q;

  AST_RXF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rx_full_q); // R7
  AST_CS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && word == W_SYS) |=> $stable(cs_o)); // R10
endmodule

// File: tb/sim_spi_reg_master.sv
module sim_spi_reg_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi, cs;
  logic        miso = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  spi_reg_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_o(cs)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  // behavioural model state
  bit       busy_m, done_m, rxf_m, acc;
  int       m_m, h_m;
  bit [7:0] tx_m, sl_m, rxb_m, ctrl_m, sys_m, slave_b;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit bit_at(bit [7:0] b, int k, bit cpha);
    if (!cpha) return b[7 - k / 2];
    if (k == 0) return 1'b0;
    return b[8 - (k + 1) / 2];
  endfunction

  function automatic bit [31:0] exp_rd(bit [4:0] a);
    case (a)
      5'h00: return {24'd0, ctrl_m};
      5'h04: return {29'd0, rxf_m, 1'b0, busy_m};
      5'h08: return {24'd0, sys_m};
      5'h10: return {24'd0, rxb_m};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_m = 0; done_m = 0; rxf_m = 0; m_m = 0; h_m = 16;
      tx_m = 0; sl_m = 0; rxb_m = 0; ctrl_m = 0; sys_m = 8'h40;
    end else begin
      acc = we && addr == 5'h0C && !busy_m;
      if ((re && addr == 5'h10) || (we && addr == 5'h04 && !wdata[2])) rxf_m = 0;
      if (done_m) begin rxf_m = 1; rxb_m = sl_m; done_m = 0; end
      if (busy_m) begin
        m_m++;
        if (m_m == 16 * h_m) begin busy_m = 0; done_m = 1; end
      end
      if (acc) begin
        busy_m = 1; m_m = 0; tx_m = wdata[7:0]; sl_m = slave_b;
        h_m = (ctrl_m[5] ? 128 : 16) * (int'(ctrl_m[4:0]) + 1);
      end
      if (we && addr == 5'h00) ctrl_m = wdata[7:0];
      if (we && addr == 5'h08) sys_m = wdata[7:0] & 8'h61;
    end
  end

  // per-clock comparison of the serial pins, and slave drive of MISO
  always @(negedge clk) begin
    int k;
    bit es, em;
    cyc++;
    if (cyc > 100000) begin
      check(0, "watchdog", "cycles", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
    if (rst_n) begin
      k  = busy_m ? m_m / h_m : 0;
      es = ctrl_m[6] ^ (busy_m && (k % 2 == 1));
      em = busy_m ? bit_at(tx_m, k, ctrl_m[7]) : 1'b0;
      check(sck == es, "R4 R5", "sck", sck, es);
      check(mosi == em, "R6 R11", "mosi", mosi, em);
      check(cs == sys_m[6], "R10", "cs", cs, sys_m[6]);
      miso = busy_m ? bit_at(sl_m, k, ctrl_m[7]) : 1'b0;
    end
  end

  task automatic bus_wr(bit [4:0] a, bit [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic bus_rd(bit [4:0] a, string req, output bit [31:0] v);
    bit [31:0] e;
    @(negedge clk);
    addr = a; re = 1'b1;
    #1;
    v = rdata;
    e = exp_rd(a);
    check(v == e, req, "read", v, e);
    @(posedge clk); #1;
    re = 1'b0;
  endtask

  task automatic wait_idle();
    bit [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      bus_rd(5'h04, "R3", v);
      if (!v[0]) break;
    end
  endtask

  task automatic xfer(bit [7:0] c, bit [7:0] tx, bit [7:0] sl, string tag);
    bit [31:0] v;
    bus_wr(5'h00, {24'd0, c});
    slave_b = sl;
    bus_wr(5'h0C, {24'd0, tx});
    bus_rd(5'h04, "R3", v);
    check(v[0] == 1'b1, "R3", {tag, " busy after start"}, v[0], 1);
    wait_idle();
    bus_rd(5'h04, "R7", v);
    check(v[2] == 1'b1, "R7", {tag, " rx full"}, v[2], 1);
    bus_rd(5'h10, "R7", v);
    check(v[7:0] == sl, "R7", {tag, " rx byte"}, v[7:0], sl);
    bus_rd(5'h04, "R8", v);
    check(v[2] == 1'b0, "R8", {tag, " rx full cleared by read"}, v[2], 0);
  endtask

  initial begin
    bit [31:0] v;
    repeat (3) @(negedge clk);
    check(sck == 1'b0 && cs == 1'b1 && mosi == 1'b0, "R1", "pins in reset",
          {sck, cs, mosi}, 3'b010);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    bus_rd(5'h00, "R1", v);
    bus_rd(5'h04, "R1", v);
    bus_rd(5'h08, "R1", v);
    check(v == 32'h40, "R1", "system reset", v, 32'h40);
    bus_rd(5'h10, "R1", v);

    bus_wr(5'h00, 32'hFFFF_FF5F);
    bus_rd(5'h00, "R2", v);
    check(v == 32'h5F, "R2", "control readback", v, 32'h5F);
    bus_wr(5'h08, 32'hFFFF_FFFF);
    bus_rd(5'h08, "R2", v);
    check(v == 32'h61, "R2", "system readback", v, 32'h61);
    bus_wr(5'h14, 32'hFFFF_FFFF);
    bus_rd(5'h14, "R2", v);
    check(v == 32'h0, "R2", "aux word", v, 0);
    bus_rd(5'h1C, "R2", v);

    bus_wr(5'h08, 32'h21);
    check(cs == 1'b0, "R10", "cs asserted", cs, 0);

    xfer(8'h00, 8'hA5, 8'h3C, "mode0 n0");
    xfer(8'hC2, 8'h96, 8'hE1, "mode3 n2");
    xfer(8'hA0, 8'h5B, 8'h81, "mode1 pre128");
    xfer(8'h41, 8'h7E, 8'h18, "mode2 n1");

    // write while busy is ignored
    bus_wr(5'h00, 32'h00);
    slave_b = 8'hC3;
    bus_wr(5'h0C, 32'h5A);
    repeat (40) @(negedge clk);
    bus_wr(5'h0C, 32'hFF);
    bus_rd(5'h04, "R9", v);
    check(v[0] == 1'b1, "R9", "still busy", v[0], 1);
    wait_idle();
    bus_rd(5'h04, "R9", v);
    check(v[0] == 1'b0, "R9", "no second exchange", v[0], 0);

    // status write clearing rules
    bus_wr(5'h04, 32'h04);
    bus_rd(5'h04, "R8", v);
    check(v[2] == 1'b1, "R8", "bit2=1 write keeps flag", v[2], 1);
    bus_wr(5'h04, 32'h00);
    bus_rd(5'h04, "R8", v);
    check(v[2] == 1'b0, "R8", "status write clears", v[2], 0);
    bus_rd(5'h10, "R9", v);
    check(v[7:0] == 8'hC3, "R9", "first byte kept", v[7:0], 8'hC3);

    bus_wr(5'h08, 32'h61);
    check(cs == 1'b1, "R10", "cs released", cs, 1);
    check(mosi == 1'b0, "R11", "mosi idle", mosi, 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule